// File: doc/BRIEF.md
# Absent-Battery Probe Sequencer

This block decides whether a single-cell pack is still attached to the charger once the charge cycle has ended. The pack may have finished normally or stopped on a safety-timer fault. The block does not wait for a voltage change to be proved absent. It drives a fixed test on the cell pin in two halves. First it pulls current out of the pin for a window and asks whether the pin has collapsed below the low-voltage mark. Then it pushes precharge current in for the same window and asks whether the pin has shot above the recharge mark. A pin that falls under a small sink and rises under a small source has only the output capacitor on it, so the pack is reported absent. Any other outcome reports the pack present, and the surrounding charge controller starts a new cycle.

After a safety-timer fault, recovery depends on the cell voltage at the moment the fault is handed over. If the cell sits above the recharge mark, the block waits for it to sag, then clears the fault and runs the probe. If the cell sits below the mark, the block keeps a small trickle current on, so that a pack being pulled out can be noticed. When the pin climbs above the mark it drops the trickle and follows the above-mark path. A toggle of the charge enable, or reset, discards all of this. The analog sources and comparators sit outside. The block only sees their one-bit flags and a millisecond tick, and it only drives enables.

Top module: `cell_probe_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, all six outputs are low; from there a charge-done start behaves as in R2.
- R2: A start request with `start_fault`=0 drives no current while `above_rch` is 1; after the first clock edge that samples `above_rch`=0, one cycle passes with every enable low and then `sink_en` goes high.
- R3: `sink_en` stays high for exactly `WIN_TICKS` cycles in which `ms_tick` is 1, and falls on the edge that samples the last of them.
- R4: If `below_low` is 0 at the last tick of the sink window, the next cycle shows `result_valid`=1 with `result_absent`=0 (present), and the block returns to idle.
- R5: If `below_low` is 1 at the last tick of the sink window, one cycle with every enable low follows, then `prechg_en` is high for `WIN_TICKS` ticks; at its last tick `above_rch`=1 gives `result_absent`=1, and `above_rch`=0 gives `result_absent`=0, both with a one-cycle `result_valid`.
- R6: Comparator flags are sampled only in the cycle carrying the last tick of a window; their values on every other cycle of the window have no effect on the result.
- R7: After an absent result the block drives nothing while `above_rch` stays 1, and reruns the whole probe (gap, then sink) once `above_rch` drops to 0.
- R8: A start request with `start_fault`=1 and `above_rch`=1 drives no current until `above_rch` is 0; that edge produces a one-cycle `fault_clear`, one cycle with no enable, then `sink_en`.
- R9: A start request with `start_fault`=1 and `above_rch`=0 raises `fault_i_en` on the next cycle; it stays high while `above_rch` is 0, and it falls on the edge that samples `above_rch`=1, after which R8 applies.
- R10: `en_toggle`=1 returns the block to idle on the next edge with every enable low and no result. `fault_clear` pulses for one cycle only if a timer fault was being held.
- R11: At most one of `sink_en`, `prechg_en`, `fault_i_en` is high in any cycle, and an enable rises only after a cycle with all three low.
- R12: `result_valid` and `fault_clear` last one cycle; a start request that arrives while a wait, recovery or probe is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, used as power-on reset |
| start_req | input | 1 | One-cycle request to begin, from charge-done or timer fault |
| start_fault | input | 1 | Qualifies `start_req`: 1 = timer fault, 0 = charge done |
| below_low | input | 1 | Comparator flag: cell pin below the low-voltage threshold |
| above_rch | input | 1 | Comparator flag: cell pin above the recharge threshold |
| ms_tick | input | 1 | One-cycle timebase pulse, nominally once per millisecond |
| en_toggle | input | 1 | One-cycle event marking a toggle of the charge enable |
| sink_en | output | 1 | Enables the detection sink current |
| prechg_en | output | 1 | Enables the precharge current |
| fault_i_en | output | 1 | Enables the small fault trickle current |
| result_valid | output | 1 | One-cycle pulse marking a probe verdict |
| result_absent | output | 1 | With `result_valid`: 1 = pack absent, 0 = pack present |
| fault_clear | output | 1 | One-cycle pulse clearing a held timer fault |

## Verification
The assertions assume that `ms_tick`, `start_req` and `en_toggle` are clean synchronous flags. The window-length property ignores a window cut short by `en_toggle` in the cycle before the enable falls, so a toggle is assumed to be the only thing that can end a window early. The stimulus drives every input just after a clock edge. It fills each window with random tick spacing and random comparator noise, and it sets the comparator to the intended verdict only on the final tick. Toggles come only as single-cycle pulses, and start requests are injected freely while the block is busy.

// File: rtl/cell_probe_pkg.sv
package cell_probe_pkg;

    typedef enum logic [2:0] {
        PS_IDLE,
        PS_DONE_WAIT,
        PS_FLT_LOW,
        PS_FLT_HIGH,
        PS_GAP_SINK,
        PS_SINK,
        PS_GAP_SRC,
        PS_SRC
    } probe_state_e;

    // current-source drive, at most one bit set
    typedef struct packed {
        logic sink;
        logic src;
        logic trickle;
    } drive_t;

    // single-cycle events produced on a state transition
    typedef struct packed {
        logic valid;
        logic absent;
        logic clr;
    } event_t;

    function automatic drive_t drive_of(probe_state_e s);
        drive_t d;
        d.sink    = (s == PS_SINK);
        d.src     = (s == PS_SRC);
        d.trickle = (s == PS_FLT_LOW);
        return d;
    endfunction

    function automatic logic in_window(probe_state_e s);
        return (s == PS_SINK) || (s == PS_SRC);
    endfunction

    function automatic logic holds_fault(probe_state_e s);
        return (s == PS_FLT_LOW) || (s == PS_FLT_HIGH);
    endfunction

endpackage

// File: rtl/probe_window_timer.sv
module probe_window_timer #(
    parameter int WIN_TICKS = 125
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic tick,
    output logic last
);
    localparam int CW = (WIN_TICKS > 1) ? $clog2(WIN_TICKS) : 1;
    localparam logic [CW-1:0] LAST_IDX = CW'(WIN_TICKS - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= (cnt_q == LAST_IDX) ? '0 : cnt_q + CW'(1);
        end
    end

    assign last = run && tick && (cnt_q == LAST_IDX);

endmodule

// File: rtl/probe_seq_fsm.sv
module probe_seq_fsm
    import cell_probe_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         start_req,
    input  logic         start_fault,
    input  logic         below_low,
    input  logic         above_rch,
    input  logic         en_toggle,
    input  logic         win_last,
    output probe_state_e state_q,
    output event_t       evt
);
    probe_state_e state_d;

    always_comb begin
        state_d = state_q;
        evt     = '0;
        if (en_toggle) begin
            state_d = PS_IDLE;
            evt.clr = holds_fault(state_q);
        end else begin
            unique case (state_q)
                PS_IDLE: begin
                    if (start_req) begin
                        if (start_fault)
                            state_d = above_rch ? PS_FLT_HIGH : PS_FLT_LOW;
                        else
                            state_d = PS_DONE_WAIT;
                    end
                end
                PS_DONE_WAIT: begin
                    if (!above_rch) state_d = PS_GAP_SINK;
                end
                PS_FLT_LOW: begin
                    if (above_rch) state_d = PS_FLT_HIGH;
                end
                PS_FLT_HIGH: begin
                    if (!above_rch) begin
                        state_d = PS_GAP_SINK;
                        evt.clr = 1'b1;
                    end
                end
                PS_GAP_SINK: state_d = PS_SINK;
                PS_GAP_SRC:  state_d = PS_SRC;
                PS_SINK: begin
                    if (win_last) begin
                        if (below_low) begin
                            state_d = PS_GAP_SRC;
                        end else begin
                            state_d   = PS_IDLE;
                            evt.valid = 1'b1;
                        end
                    end
                end
                PS_SRC: begin
                    if (win_last) begin
                        evt.valid  = 1'b1;
                        evt.absent = above_rch;
                        state_d    = above_rch ? PS_DONE_WAIT : PS_IDLE;
                    end
                end
                default: state_d = PS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= PS_IDLE;
        else     state_q <= state_d;
    end

endmodule

// File: rtl/probe_out_stage.sv
module probe_out_stage
    import cell_probe_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  probe_state_e state_q,
    input  event_t       evt,
    output logic         sink_en,
    output logic         prechg_en,
    output logic         fault_i_en,
    output logic         result_valid,
    output logic         result_absent,
    output logic         fault_clear
);
    drive_t drv;
    event_t evt_q;

    assign drv = drive_of(state_q);

    always_ff @(posedge clk) begin
        if (rst) evt_q <= '0;
        else     evt_q <= evt;
    end

    assign sink_en       = drv.sink;
    assign prechg_en     = drv.src;
    assign fault_i_en    = drv.trickle;
    assign result_valid  = evt_q.valid;
    assign result_absent = evt_q.absent;
    assign fault_clear   = evt_q.clr;

endmodule

// File: rtl/cell_probe_ctrl.sv
module cell_probe_ctrl
    import cell_probe_pkg::*;
#(
    parameter int WIN_TICKS = 125
) (
    input  logic clk,
    input  logic rst,
    input  logic start_req,
    input  logic start_fault,
    input  logic below_low,
    input  logic above_rch,
    input  logic ms_tick,
    input  logic en_toggle,
    output logic sink_en,
    output logic prechg_en,
    output logic fault_i_en,
    output logic result_valid,
    output logic result_absent,
    output logic fault_clear
);
    probe_state_e st;
    event_t       evt;
    logic         win_last;

    probe_window_timer #(.WIN_TICKS(WIN_TICKS)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (in_window(st)),
        .tick (ms_tick),
        .last (win_last)
    );

    probe_seq_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .start_req   (start_req),
        .start_fault (start_fault),
        .below_low   (below_low),
        .above_rch   (above_rch),
        .en_toggle   (en_toggle),
        .win_last    (win_last),
        .state_q     (st),
        .evt         (evt)
    );

    probe_out_stage u_out (
        .clk           (clk),
        .rst           (rst),
        .state_q       (st),
        .evt           (evt),
        .sink_en       (sink_en),
        .prechg_en     (prechg_en),
        .fault_i_en    (fault_i_en),
        .result_valid  (result_valid),
        .result_absent (result_absent),
        .fault_clear   (fault_clear)
    );

endmodule

// File: rtl/probe_checker.sv
module probe_checker #(
    parameter int WIN_TICKS = 125
) (
    input logic clk,
    input logic rst,
    input logic above_rch,
    input logic ms_tick,
    input logic en_toggle,
    input logic sink_en,
    input logic prechg_en,
    input logic fault_i_en,
    input logic result_valid,
    input logic result_absent,
    input logic fault_clear
);
    logic [31:0] win_cnt;

    always_ff @(posedge clk) begin
        if (rst)                       win_cnt <= '0;
        else if (sink_en || prechg_en) win_cnt <= win_cnt + {31'd0, ms_tick};
        else                           win_cnt <= '0;
    end

    a_r11_one_source: assert property (@(posedge clk) disable iff (rst)
        $countones({sink_en, prechg_en, fault_i_en}) <= 1);

    a_r11_gap_before_sink: assert property (@(posedge clk) disable iff (rst)
        $rose(sink_en) |-> !$past(prechg_en) && !$past(fault_i_en));

    a_r11_gap_before_src: assert property (@(posedge clk) disable iff (rst)
        $rose(prechg_en) |-> !$past(sink_en) && !$past(fault_i_en));

    a_r3_sink_window: assert property (@(posedge clk) disable iff (rst)
        $fell(sink_en) && !$past(en_toggle) |-> win_cnt == 32'(WIN_TICKS));

    a_r5_src_window: assert property (@(posedge clk) disable iff (rst)
        $fell(prechg_en) && !$past(en_toggle) |-> win_cnt == 32'(WIN_TICKS));

    a_r4_result_follows_window: assert property (@(posedge clk) disable iff (rst)
        result_valid |-> $past(sink_en) || $past(prechg_en));

    a_r4_sink_verdict_present: assert property (@(posedge clk) disable iff (rst)
        result_valid && $past(sink_en) |-> !result_absent);

    a_r12_result_pulse: assert property (@(posedge clk) disable iff (rst)
        result_valid |=> !result_valid);

    a_r12_clear_pulse: assert property (@(posedge clk) disable iff (rst)
        fault_clear |=> !fault_clear);

    a_r9_trickle_drops: assert property (@(posedge clk) disable iff (rst)
        fault_i_en && above_rch && !en_toggle |=> !fault_i_en);

    a_r10_toggle_quiet: assert property (@(posedge clk) disable iff (rst)
        en_toggle |=> !(sink_en || prechg_en || fault_i_en || result_valid));

endmodule

bind cell_probe_ctrl probe_checker #(.WIN_TICKS(WIN_TICKS)) u_probe_checker (
    .clk           (clk),
    .rst           (rst),
    .above_rch     (above_rch),
    .ms_tick       (ms_tick),
    .en_toggle     (en_toggle),
    .sink_en       (sink_en),
    .prechg_en     (prechg_en),
    .fault_i_en    (fault_i_en),
    .result_valid  (result_valid),
    .result_absent (result_absent),
    .fault_clear   (fault_clear)
);

// File: tb/cell_probe_ctrl_bench.sv
module cell_probe_ctrl_bench;
    localparam int WIN = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_req = 1'b0, start_fault = 1'b0, below_low = 1'b0;
    logic above_rch = 1'b0, ms_tick = 1'b0, en_toggle = 1'b0;
    logic sink_en, prechg_en, fault_i_en, result_valid, result_absent, fault_clear;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    cell_probe_ctrl #(.WIN_TICKS(WIN)) u_cell_probe_ctrl (
        .clk(clk), .rst(rst), .start_req(start_req), .start_fault(start_fault),
        .below_low(below_low), .above_rch(above_rch), .ms_tick(ms_tick),
        .en_toggle(en_toggle), .sink_en(sink_en), .prechg_en(prechg_en),
        .fault_i_en(fault_i_en), .result_valid(result_valid),
        .result_absent(result_absent), .fault_clear(fault_clear)
    );

    function automatic logic any_drive();
        return sink_en | prechg_en | fault_i_en;
    endfunction

    function automatic logic exp_absent(input logic f1, input logic f2);
        return f1 & f2;
    endfunction

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    // runs one window while its enable is high; final value only on last tick
    task automatic run_window(input logic on_sink, input logic fin, output logic early);
        int k = 0;
        int guard = 0;
        early = 1'b0;
        while (k < WIN && guard < 2000) begin
            logic en_now;
            en_now = on_sink ? sink_en : prechg_en;
            if (!en_now) early = 1'b1;
            ms_tick = 1'($urandom_range(0, 1));
            if (ms_tick) k++;
            below_low = 1'($urandom);
            above_rch = 1'($urandom);
            if (ms_tick && k == WIN) begin
                if (on_sink) below_low = fin;
                else         above_rch = fin;
            end
            start_req   = ($urandom_range(0, 3) == 0);
            start_fault = 1'($urandom);
            cyc();
            guard++;
        end
        ms_tick = 1'b0; start_req = 1'b0; start_fault = 1'b0; below_low = 1'b0;
        above_rch = on_sink ? 1'b0 : fin;
    endtask

    task automatic probe(input logic f1, input logic f2);
        logic early;
        run_window(1'b1, f1, early);
        chk("R3 sink window full length", early, 1'b0);
        chk("R3 sink off after last tick", sink_en, 1'b0);
        if (!f1) begin
            chk("R4 verdict pulse", result_valid, 1'b1);
            chk("R4 verdict present", result_absent, 1'b0);
            cyc();
            chk("R12 verdict one cycle", result_valid, 1'b0);
        end else begin
            chk("R11 gap before source", any_drive(), 1'b0);
            chk("R4 no verdict after low sink", result_valid, 1'b0);
            cyc();
            chk("R5 source on", prechg_en, 1'b1);
            run_window(1'b0, f2, early);
            chk("R5 source window full length", early, 1'b0);
            chk("R5 source off", prechg_en, 1'b0);
            chk("R5 verdict pulse", result_valid, 1'b1);
            chk("R6 verdict from last tick only", result_absent, exp_absent(f1, f2));
            cyc();
            chk("R12 verdict one cycle", result_valid, 1'b0);
        end
    endtask

    task automatic enter_from_done();
        start_req = 1'b1; start_fault = 1'b0; above_rch = 1'b1;
        cyc();
        start_req = 1'b0;
        for (int i = 0; i < 3; i++) begin
            chk("R2 no current while above", any_drive(), 1'b0);
            cyc();
        end
        above_rch = 1'b0;
        cyc();
        chk("R2 gap cycle", any_drive(), 1'b0);
        cyc();
        chk("R2 sink starts", sink_en, 1'b1);
    endtask

    task automatic enter_fault_high();
        start_req = 1'b1; start_fault = 1'b1; above_rch = 1'b1;
        cyc();
        start_req = 1'b0; start_fault = 1'b0;
        for (int i = 0; i < 3; i++) begin
            chk("R8 no current while above", any_drive(), 1'b0);
            chk("R8 no clear while above", fault_clear, 1'b0);
            cyc();
        end
        above_rch = 1'b0;
        cyc();
        chk("R8 clear pulse", fault_clear, 1'b1);
        chk("R8 gap cycle", any_drive(), 1'b0);
        cyc();
        chk("R8 clear one cycle", fault_clear, 1'b0);
        chk("R8 sink starts", sink_en, 1'b1);
    endtask

    task automatic enter_fault_low();
        start_req = 1'b1; start_fault = 1'b1; above_rch = 1'b0;
        cyc();
        start_req = 1'b0; start_fault = 1'b0;
        for (int i = 0; i < 3; i++) begin
            chk("R9 trickle while below", fault_i_en, 1'b1);
            cyc();
        end
        above_rch = 1'b1;
        cyc();
        chk("R9 trickle off above", fault_i_en, 1'b0);
        chk("R9 no clear yet", fault_clear, 1'b0);
        cyc();
        chk("R9 waits while above", any_drive(), 1'b0);
        above_rch = 1'b0;
        cyc();
        chk("R9 clear after drop", fault_clear, 1'b1);
        cyc();
        chk("R9 sink starts", sink_en, 1'b1);
    endtask

    task automatic rerun_after_absent();
        for (int i = 0; i < 3; i++) begin
            chk("R7 idle while above", any_drive(), 1'b0);
            cyc();
        end
        above_rch = 1'b0;
        cyc();
        chk("R7 gap cycle", any_drive(), 1'b0);
        cyc();
        chk("R7 probe repeats", sink_en, 1'b1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'h1bad5eed));
        rst = 1'b1;
        repeat (3) cyc();
        chk("R1 reset drives", any_drive(), 1'b0);
        chk("R1 reset verdict", result_valid, 1'b0);
        chk("R1 reset clear", fault_clear, 1'b0);
        rst = 1'b0;
        cyc();
        chk("R1 idle after reset", any_drive() | result_valid | result_absent | fault_clear, 1'b0);

        // directed: every verdict combination
        enter_from_done(); probe(1'b0, 1'b0);
        enter_from_done(); probe(1'b1, 1'b0);
        enter_from_done(); probe(1'b1, 1'b1);
        rerun_after_absent(); probe(1'b0, 1'b1);

        // directed: start request ignored while waiting (R12)
        start_req = 1'b1; start_fault = 1'b0; above_rch = 1'b1;
        cyc();
        start_req = 1'b1; start_fault = 1'b1; above_rch = 1'b0;
        cyc();
        start_req = 1'b0; start_fault = 1'b0;
        chk("R12 busy start ignored", fault_i_en, 1'b0);
        cyc();
        chk("R12 busy start ignored", sink_en, 1'b1);
        probe(1'b0, 1'b0);

        // directed: toggle while a fault is held (R10)
        start_req = 1'b1; start_fault = 1'b1; above_rch = 1'b0;
        cyc();
        start_req = 1'b0; start_fault = 1'b0;
        chk("R9 trickle on", fault_i_en, 1'b1);
        en_toggle = 1'b1;
        cyc();
        en_toggle = 1'b0;
        chk("R10 toggle drops trickle", any_drive(), 1'b0);
        chk("R10 toggle clears fault", fault_clear, 1'b1);
        cyc();
        chk("R10 clear one cycle", fault_clear, 1'b0);
        chk("R10 stays idle", any_drive(), 1'b0);

        // directed: toggle inside a sink window (R10)
        enter_from_done();
        ms_tick = 1'b1; below_low = 1'b0;
        cyc();
        ms_tick = 1'b0; en_toggle = 1'b1;
        cyc();
        en_toggle = 1'b0;
        chk("R10 toggle stops sink", sink_en, 1'b0);
        chk("R10 toggle no verdict", result_valid, 1'b0);
        chk("R10 no clear without fault", fault_clear, 1'b0);
        ms_tick = 1'b1;
        repeat (WIN + 2) cyc();
        ms_tick = 1'b0;
        chk("R10 remains idle", any_drive() | result_valid, 1'b0);

        // random mix of entry paths and verdicts
        for (int it = 0; it < 30; it++) begin
            int path;
            logic f1, f2;
            path = $urandom_range(0, 2);
            f1 = 1'($urandom);
            f2 = 1'($urandom);
            if (path == 0)      enter_from_done();
            else if (path == 1) enter_fault_high();
            else                enter_fault_low();
            probe(f1, f2);
            if (exp_absent(f1, f2)) begin
                rerun_after_absent();
                probe(1'b0, 1'b0);
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule